// File: doc/BRIEF.md
# Predicated Contiguous Vector Load Sequencer

This block carries out one masked contiguous load into a vector of `VLEN` bits. A start pulse captures a 64-bit base address, a signed 4-bit offset counted in whole vectors, a byte-granular predicate and an element-width code. The block then walks the elements in ascending order. For each active element it issues one 32-bit read on a valid/ready request port and waits for the single matching response. Inactive elements are never read.

Each returned word is zero-extended into its element slot, and every slot belonging to an inactive element is cleared. A one-cycle `done` pulse marks the finished vector on `result`, which holds its value until the next accepted start. A stack-pointer-base flag does not change addressing. It only decides whether a one-cycle alignment-check pulse is raised for the load.

Top module: `pvl_seq`

## Requirements
- R1: The read address for element e is base + (imm × NE + e) × 4, computed modulo 2^64, where imm is the 4-bit two's-complement offset (-8 to 7) and NE is the element count.
- R2: Element e is active when predicate bit e × (esize/8) is 1; every other predicate bit is ignored. Exactly one read is issued per active element, in ascending element order, and none for an inactive element.
- R3: `elem_sel` encodes the element width: 0 selects 32 bits, 1 selects 64 bits, 2 and 3 select 128 bits. NE = VLEN / esize.
- R4: An active element's word is written zero-extended at bit offset e × esize of `result`; all bits of inactive elements are 0.
- R5: At most one read is outstanding. A request that is not accepted keeps `rd_req_valid` high and its address unchanged, and no new request follows in the cycle after an acceptance.
- R6: `done` is high for exactly one cycle, in the cycle after the last response is taken, with `busy` low. `result` then holds until the next accepted start.
- R7: With no active element, no read is issued, `done` pulses in the cycle after the start, and `result` is all zeros.
- R8: `align_chk` pulses in the cycle after an accepted start when `sp_base` is 1 and either some element is active or `chk_idle_sp` is 1; otherwise it stays 0.
- R9: `start` is ignored while `busy` is high; the running load and its result are unaffected.
- R10: A synchronous reset clears `result`, `busy`, `done`, `align_chk` and `rd_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a load when idle |
| base_addr | input | AW | Base byte address |
| imm_off | input | 4 | Signed offset in whole vectors |
| pred_mask | input | VLEN/8 | Per-byte predicate |
| elem_sel | input | 2 | Element width code |
| sp_base | input | 1 | Base comes from the stack pointer |
| chk_idle_sp | input | 1 | Also request the alignment check when no element is active |
| busy | output | 1 | Load in progress |
| align_chk | output | 1 | Alignment-check request pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| done | output | 1 | Load complete pulse |
| result | output | VLEN | Assembled vector |

## Verification
The load is tried with every element width, each with a dense predicate and a sparse predicate. Junk bits are placed inside each element's predicate group, which tells the leading-bit rule apart from an any-bit rule. A negative offset and a base near the top of the address space separate correct two's-complement scaling and wrap from unsigned or truncated arithmetic. An all-inactive predicate and a start pulsed mid-load exercise the skip path and the busy lock-out. Back-pressured request acceptance shows that the request is held steady and that reads are not dropped or repeated.

// File: rtl/pvl_pkg.sv
`timescale 1ns/1ps
package pvl_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } pvl_state_e;

   // width code: 0 -> 32, 1 -> 64, 2/3 -> 128
   function automatic logic [1:0] esz_norm(input logic [1:0] code);
      return (code == 2'd3) ? 2'd2 : code;
   endfunction

endpackage

// File: rtl/pvl_lane_map.sv
`timescale 1ns/1ps
module pvl_lane_map #(
   parameter int VLEN = 256
) (
   input  logic [VLEN/8-1:0]  pred,
   input  logic [1:0]         esz,
   output logic [VLEN/32-1:0] act
);
   localparam int MAXE = VLEN / 32;

   for (genvar e = 0; e < MAXE; e++) begin : g_lane
      logic a32, a64, a128;
      assign a32 = pred[e*4];
      if (e < MAXE/2) begin : g_w64
         assign a64 = pred[e*8];
      end else begin : g_n64
         assign a64 = 1'b0;
      end
      if (e < MAXE/4) begin : g_w128
         assign a128 = pred[e*16];
      end else begin : g_n128
         assign a128 = 1'b0;
      end
      always_comb begin
         case (esz)
            2'd1:    act[e] = a64;
            2'd2:    act[e] = a128;
            default: act[e] = a32;
         endcase
      end
   end

endmodule

// File: rtl/pvl_first_set.sv
`timescale 1ns/1ps
module pvl_first_set #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   if (N < 2) begin : g_bad_n
      $error("pvl_first_set: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign any = |vec;

endmodule

// File: rtl/pvl_agen.sv
`timescale 1ns/1ps
module pvl_agen #(
   parameter int AW    = 64,
   parameter int MAXE  = 8,
   parameter int IMM_W = 4,
   parameter int IDX_W = $clog2(MAXE)
) (
   input  logic [AW-1:0]    base,
   input  logic [IMM_W-1:0] imm,
   input  logic [1:0]       esz,
   input  logic [IDX_W-1:0] idx,
   output logic [AW-1:0]    addr
);
   localparam int LOGM = $clog2(MAXE);

   logic [AW-1:0] imm_ext;
   logic [AW-1:0] scaled;
   logic [AW-1:0] elem_off;
   logic [5:0]    shamt;

   // imm * NE * 4, NE = MAXE >> esz (power of two)
   assign imm_ext  = {{(AW-IMM_W){imm[IMM_W-1]}}, imm};
   assign shamt    = 6'(LOGM + 2) - 6'(esz);
   assign scaled   = imm_ext << shamt;
   assign elem_off = AW'(idx) << 2;
   assign addr     = base + scaled + elem_off;

endmodule

// File: rtl/pvl_packer.sv
`timescale 1ns/1ps
module pvl_packer #(
   parameter int VLEN  = 256,
   parameter int MAXE  = VLEN / 32,
   parameter int IDX_W = $clog2(MAXE)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_esz,
   input  logic [31:0]      wr_data,
   output logic [VLEN-1:0]  result
);
   logic [IDX_W+1:0] wsel;
   assign wsel = {2'b00, wr_idx} << wr_esz;

   for (genvar w = 0; w < MAXE; w++) begin : g_word
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
         if (rst || clear) begin
            word_q <= '0;
         end else if (wr_en && (wsel == (IDX_W+2)'(w))) begin
            word_q <= wr_data;
         end
      end
      assign result[w*32 +: 32] = word_q;
   end

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!clear && !wr_en) |=> $stable(result)) else $error("result moved"); // R6
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
      clear |=> (result == '0)) else $error("clear left data"); // R7

endmodule

// File: rtl/pvl_seq.sv
`timescale 1ns/1ps
module pvl_seq
   import pvl_pkg::*;
#(
   parameter int VLEN  = 256,
   parameter int AW    = 64,
   parameter int IMM_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [AW-1:0]     base_addr,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic [VLEN/8-1:0] pred_mask,
   input  logic [1:0]        elem_sel,
   input  logic              sp_base,
   input  logic              chk_idle_sp,
   output logic              busy,
   output logic              align_chk,
   output logic              rd_req_valid,
   input  logic              rd_req_ready,
   output logic [AW-1:0]     rd_req_addr,
   input  logic              rd_rsp_valid,
   input  logic [31:0]       rd_rsp_data,
   output logic              done,
   output logic [VLEN-1:0]   result
);
   localparam int MAXE  = VLEN / WORD_W;
   localparam int IDX_W = $clog2(MAXE);

   if ((VLEN % 128) != 0 || VLEN < 128) begin : g_bad_vlen
      $error("pvl_seq: VLEN must be a positive multiple of 128");
   end
   if (AW < 8) begin : g_bad_aw
      $error("pvl_seq: AW too small");
   end
   if (IMM_W < 2) begin : g_bad_imm
      $error("pvl_seq: IMM_W too small");
   end

   pvl_state_e       state_q;
   logic [AW-1:0]    base_q;
   logic [IMM_W-1:0] imm_q;
   logic [1:0]       esz_q;
   logic [MAXE-1:0]  pend_q;
   logic [IDX_W-1:0] cur_q;
   logic             done_q;
   logic             align_q;

   logic [1:0]       esz_in;
   logic [MAXE-1:0]  act_now;
   logic [IDX_W-1:0] first_now;
   logic             any_now;
   logic [MAXE-1:0]  pend_next;
   logic [IDX_W-1:0] first_nx;
   logic             any_nx;
   logic             start_take;
   logic             rsp_take;

   assign esz_in     = esz_norm(elem_sel);
   assign start_take = start && (state_q == ST_IDLE);
   assign rsp_take   = rd_rsp_valid && (state_q == ST_WAIT);
   assign pend_next  = pend_q & ~(MAXE'(1) << cur_q);

   pvl_lane_map #(.VLEN(VLEN)) u_lanes (
      .pred (pred_mask),
      .esz  (esz_in),
      .act  (act_now)
   );

   pvl_first_set #(.N(MAXE), .IDX_W(IDX_W)) u_pick_start (
      .vec (act_now),
      .idx (first_now),
      .any (any_now)
   );

   pvl_first_set #(.N(MAXE), .IDX_W(IDX_W)) u_pick_next (
      .vec (pend_next),
      .idx (first_nx),
      .any (any_nx)
   );

   pvl_agen #(.AW(AW), .MAXE(MAXE), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_agen (
      .base (base_q),
      .imm  (imm_q),
      .esz  (esz_q),
      .idx  (cur_q),
      .addr (rd_req_addr)
   );

   pvl_packer #(.VLEN(VLEN), .MAXE(MAXE), .IDX_W(IDX_W)) u_pack (
      .clk     (clk),
      .rst     (rst),
      .clear   (start_take),
      .wr_en   (rsp_take),
      .wr_idx  (cur_q),
      .wr_esz  (esz_q),
      .wr_data (rd_rsp_data),
      .result  (result)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         imm_q   <= '0;
         esz_q   <= '0;
         pend_q  <= '0;
         cur_q   <= '0;
         done_q  <= 1'b0;
         align_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         align_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  base_q  <= base_addr;
                  imm_q   <= imm_off;
                  esz_q   <= esz_in;
                  pend_q  <= act_now;
                  align_q <= sp_base && (any_now || chk_idle_sp);
                  if (any_now) begin
                     cur_q   <= first_now;
                     state_q <= ST_REQ;
                  end else begin
                     done_q  <= 1'b1;
                  end
               end
            end
            ST_REQ: begin
               if (rd_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rd_rsp_valid) begin
                  pend_q <= pend_next;
                  if (any_nx) begin
                     cur_q   <= first_nx;
                     state_q <= ST_REQ;
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (state_q != ST_IDLE);
   assign rd_req_valid = (state_q == ST_REQ);
   assign done         = done_q;
   assign align_chk    = align_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)))
      else $error("request dropped or changed"); // R5
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
      (rd_req_valid && rd_req_ready) |=> !rd_req_valid)
      else $error("second request while one outstanding"); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done) else $error("done wider than one cycle"); // R6
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy) else $error("done while busy"); // R6
   AST_ALIGN_CTX: assert property (@(posedge clk) disable iff (rst)
      align_chk |-> (busy || done)) else $error("stray alignment request"); // R8
   AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
      (busy && start && !rsp_take) |=> busy) else $error("start disturbed a load"); // R9

endmodule

// File: tb/pvl_seq_tb.sv
`timescale 1ns/1ps
module pvl_seq_tb;
   localparam int VL  = 256;
   localparam int PWB = VL / 8;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [63:0]    base_addr = '0;
   logic [3:0]     imm_off = '0;
   logic [PWB-1:0] pred_mask = '0;
   logic [1:0]     elem_sel = '0;
   logic           sp_base = 1'b0;
   logic           chk_idle_sp = 1'b0;
   logic           busy, align_chk, rd_req_valid, done;
   logic           rd_req_ready = 1'b1;
   logic [63:0]    rd_req_addr;
   logic           rd_rsp_valid = 1'b0;
   logic [31:0]    rd_rsp_data = '0;
   logic [VL-1:0]  result;

   int checks = 0;
   int fails = 0;
   int done_cnt = 0;
   int exp_done = 0;
   bit bp = 1'b0;
   int cyc = 0;
   bit pend = 1'b0;
   logic [63:0] pend_addr;

   logic [63:0]   exp_addr_q[$];
   logic [VL-1:0] exp_res_q[$];

   always #2.5 clk = ~clk;

   pvl_seq #(.VLEN(VL)) u_dut (
      .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
      .imm_off(imm_off), .pred_mask(pred_mask), .elem_sel(elem_sel),
      .sp_base(sp_base), .chk_idle_sp(chk_idle_sp), .busy(busy),
      .align_chk(align_chk), .rd_req_valid(rd_req_valid),
      .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .done(done), .result(result)
   );

   function automatic logic [31:0] mem_word(input logic [63:0] a);
      return a[31:0] ^ {a[47:32], a[63:48]} ^ 32'h5A3C_0F11;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VL-1:0] got, input logic [VL-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   // memory model: one-cycle response, optional back-pressure
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         rd_rsp_valid = 1'b0;
         if (pend) begin
            rd_rsp_valid = 1'b1;
            rd_rsp_data  = mem_word(pend_addr);
            pend = 1'b0;
         end
         rd_req_ready = bp ? ((cyc % 3) == 0) : 1'b1;
         if (!rst && rd_req_valid && rd_req_ready) begin
            pend = 1'b1;
            pend_addr = rd_req_addr;
            if (exp_addr_q.size() == 0) begin
               chk(1'b0, "R2", "read for inactive lane", VL'(rd_req_addr), '0);
            end else begin
               logic [63:0] ea;
               ea = exp_addr_q.pop_front();
               chk(rd_req_addr == ea, "R1", "read address", VL'(rd_req_addr), VL'(ea));
            end
         end
      end
   end

   // monitor: result scoreboard on done
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && done) begin
            done_cnt++;
            if (exp_res_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected done", VL'(1), '0);
            end else begin
               logic [VL-1:0] er;
               er = exp_res_q.pop_front();
               chk(result == er, "R4", "assembled vector", result, er);
               chk(!busy, "R6", "busy with done", VL'(busy), '0);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
   end

   task automatic run_load(input logic [63:0] b, input logic [3:0] im,
                           input logic [PWB-1:0] p, input logic [1:0] es,
                           input bit sp, input bit ci, input bit poke);
      int esize;
      int ne;
      int prev;
      bit any;
      logic [VL-1:0] r;
      longint s;
      logic [63:0] a;
      esize = (es == 2'd0) ? 32 : (es == 2'd1) ? 64 : 128;   // R3
      ne = VL / esize;
      any = 1'b0;
      r = '0;
      s = longint'($signed(im));
      for (int e = 0; e < ne; e++) begin
         if (p[e*(esize/8)]) begin                            // R2
            any = 1'b1;
            a = b + 64'((s * ne + e) * 4);
            exp_addr_q.push_back(a);
            r[e*esize +: 32] = mem_word(a);
         end
      end
      exp_res_q.push_back(r);
      exp_done++;
      prev = done_cnt;
      @(negedge clk);
      base_addr = b; imm_off = im; pred_mask = p; elem_sel = es;
      sp_base = sp; chk_idle_sp = ci; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(align_chk == (sp && (any || ci)), "R8", "alignment pulse",
          VL'(align_chk), VL'(sp && (any || ci)));
      if (poke && any) begin
         chk(busy == 1'b1, "R9", "busy before poke", VL'(busy), VL'(1));
         base_addr = ~b; imm_off = ~im; pred_mask = '1; elem_sel = 2'd0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (done_cnt == prev) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(result == r, "R6", "result hold after done", result, r);
      chk(!busy, "R9", "idle after load", VL'(busy), '0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk(result == '0 && !busy && !done && !rd_req_valid && !align_chk,
          "R10", "reset state", result, '0);
      rst = 1'b0;
      @(negedge clk);

      // R3 32-bit, all active, zero offset
      run_load(64'h0000_0000_1000_0000, 4'h0, '1, 2'd0, 1'b0, 1'b0, 1'b0);
      // R1 negative offset, R2 junk predicate bits, 64-bit elements
      run_load(64'h0000_0000_0000_2000, 4'h8, 32'h01F1_00FF, 2'd1, 1'b1, 1'b0, 1'b0);
      // R2 128-bit, only element 1 leading bit set
      run_load(64'h0000_0001_0000_0040, 4'h7, 32'h0001_FFFE, 2'd2, 1'b0, 1'b0, 1'b0);
      // R3 code 3 behaves as 128, R1 wrap past 2^64
      run_load(64'hFFFF_FFFF_FFFF_FFF0, 4'h7, '1, 2'd3, 1'b1, 1'b0, 1'b0);
      // R7 no active element, idle check requested and not
      run_load(64'h0000_0000_0000_8000, 4'h3, 32'hEEEE_EEEE, 2'd0, 1'b1, 1'b1, 1'b0);
      run_load(64'h0000_0000_0000_8000, 4'h3, 32'hEEEE_EEEE, 2'd0, 1'b1, 1'b0, 1'b0);
      chk(exp_addr_q.size() == 0, "R7", "reads pending", VL'(exp_addr_q.size()), '0);
      // R5 back-pressure
      bp = 1'b1;
      run_load(64'h0000_0000_0003_0000, 4'hF, 32'h1011_0101, 2'd0, 1'b1, 1'b0, 1'b0);
      run_load(64'h0000_0000_0004_0100, 4'h2, '1, 2'd1, 1'b0, 1'b0, 1'b0);
      bp = 1'b0;
      // R9 start during busy ignored
      run_load(64'h0000_0000_0005_0000, 4'h1, '1, 2'd1, 1'b0, 1'b0, 1'b1);

      repeat (4) @(negedge clk);
      chk(done_cnt == exp_done, "R6", "done count", VL'(done_cnt), VL'(exp_done));
      chk(exp_addr_q.size() == 0, "R2", "reads missing", VL'(exp_addr_q.size()), '0);

      // R10 synchronous reset clears the held result
      rst = 1'b1;
      @(negedge clk);
      chk(result == '0 && !busy && !done, "R10", "reset clears", result, '0);
      rst = 1'b0;
      @(negedge clk);
      summary();
   end

endmodule